// File: doc/BRIEF.md
# PCI Posted Write Target Acceptor

This block is the target half of one bridge port. It watches the shared PCI bus for address phases. It claims a memory write only when all of these hold: the command is a posted kind, the external address decoder reports a hit outside the legacy video window, and the downstream queue has room for the address entry plus at least one DWORD of data. It claims with medium decode timing and accepts data with no wait states.

Every accepted beat is pushed into a posted-write queue as one entry. The block ends a burst in one of two ways:
- normally, when the initiator completes its final data phase;
- with a target disconnect, which carries data on the current phase, when the next DWORD would cross a write boundary or would find no queue slot.

Memory Write bursts are bounded by a cache line whose size is given on a configuration input. Memory Write and Invalidate bursts are bounded by an aligned 4 KB page. Delayed transactions are left unclaimed for other logic. Reads and parity are not handled here.

Top module: `pw_target`

## Requirements
- R1: Only command codes 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) on C/BE# are claimed, and only with `addr_hit`=1 and `vga_hit`=0. Codes 4'b0011 (I/O write) and 4'b1011 (configuration write), a miss, or a video-window hit leave DEVSEL#, TRDY#, STOP# deasserted and write nothing to the queue.
- R2: An address phase is a clock edge where FRAME# is sampled low while both FRAME# and IRDY# were high at the previous edge. For a claimed write, DEVSEL# goes low two clocks after that edge (medium decode) and TRDY# goes low one clock after DEVSEL#.
- R3: A write is claimed only if `q_free` is at least 2 when the address phase is sampled.
- R4: While TRDY# is low, every edge with IRDY# low transfers one DWORD and produces exactly one queue write in the next cycle. Edges with IRDY# high produce none, and no target wait state is ever inserted.
- R5: The beat sampled with FRAME# high is the final one. Its queue entry has `q_eot`=1, and DEVSEL#, TRDY# and STOP# are all high one clock after it.
- R6: For code 4'b0111, STOP# is asserted on the data phase whose DWORD address is the last of a cache line. `cls_dw` gives the line size in DWORDs as a nonzero power of two.
- R7: For code 4'b1111, STOP# is asserted only on the data phase whose DWORD address is the last of an aligned 4 KB page (byte address bits 11:2 all ones). The cache-line size has no effect.
- R8: With `q_free`=F at the address phase, at most F-1 data beats are accepted. STOP# is asserted on beat F-1 if the initiator would continue.
- R9: STOP# is asserted together with TRDY#, so the disconnect beat transfers. After that beat TRDY# goes high, STOP# and DEVSEL# stay low while FRAME# is low, and all three go high one clock after FRAME# is sampled high.
- R10: The first queue entry of a transaction has `q_addr_ent`=1, `q_data` = address with bits 1:0 cleared, and `q_be` = command code. Each data entry carries AD in `q_data` and the inverted C/BE# in `q_be`. A disconnect beat also has `q_eot`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | synchronous active-high reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| ad | input | AD_W | address/data bus |
| cbe_n | input | 4 | command / byte enables, active low |
| addr_hit | input | 1 | address decoder hit for this port |
| vga_hit | input | 1 | address lies in the legacy video window |
| cls_dw | input | CLS_W | cache-line size in DWORDs |
| q_free | input | FREE_W | free entries in the posted queue |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |
| q_wr | output | 1 | queue write strobe |
| q_addr_ent | output | 1 | entry is an address entry |
| q_data | output | AD_W | entry address or data |
| q_be | output | 4 | command (address entry) or byte enables |
| q_eot | output | 1 | last entry of the transaction |

## Verification
With edge E0 as the address-phase edge, DEVSEL# is due after E0+1 and TRDY# after E0+2. The STOP# decision for a beat is already visible on the clock before that beat's edge. Each queue entry appears one clock after the edge that accepted its beat, and the release of the bus signals appears one clock after the final beat or after FRAME# is seen high during a disconnect. The bench drives and samples only on falling edges. It records the cycle in which DEVSEL# and TRDY# first go low, counted from the address phase, and logs queue strobes on falling edges so each entry is compared after its registering edge.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEC,
    S_CLAIM,
    S_DATA,
    S_HOLD
  } pw_state_e;

  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;
endpackage

// File: rtl/pw_claim_filter.sv
module pw_claim_filter
  import pw_pkg::*;
#(
  parameter int FREE_W = 6
) (
  input  logic [3:0]        cmd,
  input  logic              addr_hit,
  input  logic              vga_hit,
  input  logic [FREE_W-1:0] q_free,
  output logic              take
);
  logic posted_cmd;
  logic room;

  assign posted_cmd = (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_INV);
  assign room       = q_free >= FREE_W'(2);
  assign take       = posted_cmd && addr_hit && !vga_hit && room;
endmodule

// File: rtl/pw_boundary.sv
module pw_boundary #(
  parameter int DW_W      = 30,
  parameter int CLS_W     = 8,
  parameter int PAGE_DW_W = 10
) (
  input  logic [DW_W-1:0]  dw_addr,
  input  logic             whole_page,
  input  logic [CLS_W-1:0] line_dw,
  output logic             last_in_block
);
  logic [CLS_W-1:0] mask;
  logic             line_end;
  logic             page_end;

  assign mask          = line_dw - CLS_W'(1);
  assign line_end      = (dw_addr[CLS_W-1:0] & mask) == mask;
  assign page_end      = &dw_addr[PAGE_DW_W-1:0];
  assign last_in_block = whole_page ? page_end : line_end;
endmodule

// File: rtl/pw_target.sv
module pw_target
  import pw_pkg::*;
#(
  parameter int AD_W      = 32,
  parameter int FREE_W    = 6,
  parameter int CLS_W     = 8,
  parameter int PAGE_DW_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [AD_W-1:0]   ad,
  input  logic [3:0]        cbe_n,
  input  logic              addr_hit,
  input  logic              vga_hit,
  input  logic [CLS_W-1:0]  cls_dw,
  input  logic [FREE_W-1:0] q_free,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              q_wr,
  output logic              q_addr_ent,
  output logic [AD_W-1:0]   q_data,
  output logic [3:0]        q_be,
  output logic              q_eot
);
  localparam int DW_W = AD_W - 2;

  pw_state_e         state;
  logic              frame_q, irdy_q;
  logic [DW_W-1:0]   dw_addr;
  logic [DW_W-1:0]   dw_next;
  logic [3:0]        cmd_q;
  logic [FREE_W-1:0] cred;
  logic              addr_phase, take, edge_cur, edge_nxt;

  assign addr_phase = !frame_n && frame_q && irdy_q;
  assign dw_next    = dw_addr + DW_W'(1);

  pw_claim_filter #(.FREE_W(FREE_W)) u_filter (
    .cmd(cbe_n), .addr_hit(addr_hit), .vga_hit(vga_hit),
    .q_free(q_free), .take(take)
  );

  pw_boundary #(.DW_W(DW_W), .CLS_W(CLS_W), .PAGE_DW_W(PAGE_DW_W)) u_bnd_cur (
    .dw_addr(dw_addr), .whole_page(cmd_q[3]), .line_dw(cls_dw),
    .last_in_block(edge_cur)
  );

  pw_boundary #(.DW_W(DW_W), .CLS_W(CLS_W), .PAGE_DW_W(PAGE_DW_W)) u_bnd_nxt (
    .dw_addr(dw_next), .whole_page(cmd_q[3]), .line_dw(cls_dw),
    .last_in_block(edge_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      frame_q    <= 1'b1;
      irdy_q     <= 1'b1;
      devsel_n   <= 1'b1;
      trdy_n     <= 1'b1;
      stop_n     <= 1'b1;
      q_wr       <= 1'b0;
      q_addr_ent <= 1'b0;
      q_eot      <= 1'b0;
      q_data     <= '0;
      q_be       <= '0;
      dw_addr    <= '0;
      cmd_q      <= '0;
      cred       <= '0;
    end else begin
      frame_q    <= frame_n;
      irdy_q     <= irdy_n;
      q_wr       <= 1'b0;
      q_addr_ent <= 1'b0;
      q_eot      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (addr_phase && take) begin
            state   <= S_DEC;
            dw_addr <= ad[AD_W-1:2];
            cmd_q   <= cbe_n;
            cred    <= q_free - FREE_W'(1);
          end
        end
        S_DEC: begin
          devsel_n   <= 1'b0;
          q_wr       <= 1'b1;
          q_addr_ent <= 1'b1;
          q_data     <= {dw_addr, 2'b00};
          q_be       <= cmd_q;
          state      <= S_CLAIM;
        end
        S_CLAIM: begin
          trdy_n <= 1'b0;
          stop_n <= !(edge_cur || cred == FREE_W'(1));
          state  <= S_DATA;
        end
        S_DATA: begin
          if (!irdy_n) begin
            q_wr    <= 1'b1;
            q_data  <= ad;
            q_be    <= ~cbe_n;
            q_eot   <= frame_n || !stop_n;
            dw_addr <= dw_next;
            cred    <= cred - FREE_W'(1);
            if (frame_n) begin
              devsel_n <= 1'b1;
              trdy_n   <= 1'b1;
              stop_n   <= 1'b1;
              state    <= S_IDLE;
            end else if (!stop_n) begin
              trdy_n <= 1'b1;
              state  <= S_HOLD;
            end else begin
              stop_n <= !(edge_nxt || cred == FREE_W'(2));
            end
          end
        end
        S_HOLD: begin
          if (frame_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_trdy_after_devsel: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> trdy_n);
  a_r2_trdy_next_clock: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |=> !trdy_n);
  a_r3_room_at_claim: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> ($past(q_free, 2) >= FREE_W'(2)));
  a_r4_beat_queued: assert property (@(posedge clk) disable iff (rst)
    (!irdy_n && !trdy_n && !devsel_n) |=> q_wr);
  a_r5_release_after_last: assert property (@(posedge clk) disable iff (rst)
    (!irdy_n && !trdy_n && frame_n) |=> (trdy_n && devsel_n && stop_n));
  a_r9_stop_held: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && !frame_n) |=> !stop_n);
  a_r9_stop_with_devsel: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> !devsel_n);
  a_r10_addr_not_eot: assert property (@(posedge clk) disable iff (rst)
    (q_wr && q_addr_ent) |-> !q_eot);
endmodule

// File: tb/tb_pw_target.sv
`timescale 1ns/1ps
module tb_pw_target;
  localparam int AD_W = 32;
  localparam int FREE_W = 6;
  localparam int CLS_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [AD_W-1:0] ad = '0;
  logic [3:0] cbe_n = 4'hF;
  logic addr_hit = 1'b0, vga_hit = 1'b0;
  logic [CLS_W-1:0] cls_dw = 8'd16;
  logic [FREE_W-1:0] q_free = '0;
  logic devsel_n, trdy_n, stop_n, q_wr, q_addr_ent, q_eot;
  logic [AD_W-1:0] q_data;
  logic [3:0] q_be;

  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pw_target #(.AD_W(AD_W), .FREE_W(FREE_W), .CLS_W(CLS_W)) dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .addr_hit(addr_hit), .vga_hit(vga_hit), .cls_dw(cls_dw),
    .q_free(q_free), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .q_wr(q_wr), .q_addr_ent(q_addr_ent), .q_data(q_data), .q_be(q_be),
    .q_eot(q_eot)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [7:0]  n;
    logic [5:0]  free;
    logic [7:0]  cls;
    logic        hit;
    logic        vga;
    logic        stall;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0111, 32'h0000_1000, 8'd4, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_1038, 8'd8, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b1111, 32'h0000_2FF8, 8'd6, 6'd30, 8'd8,  1'b1, 1'b0, 1'b0},
    '{4'b1111, 32'h0000_2038, 8'd6, 6'd30, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_0000, 8'd8, 6'd4,  8'd64, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_0400, 8'd4, 6'd1,  8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0011, 32'h0000_0400, 8'd4, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h000A_0000, 8'd4, 6'd20, 8'd16, 1'b1, 1'b1, 1'b0},
    '{4'b0111, 32'h0000_0800, 8'd4, 6'd20, 8'd16, 1'b0, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_0100, 8'd5, 6'd40, 8'd32, 1'b1, 1'b0, 1'b1},
    '{4'b1011, 32'h0000_0100, 8'd2, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_0200, 8'd1, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_003C, 8'd3, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h0000_1038, 8'd2, 6'd20, 8'd16, 1'b1, 1'b0, 1'b0}
  };

  logic [AD_W-1:0] e_data [64];
  logic [3:0]      e_be   [64];
  logic            e_addr [64];
  logic            e_eot  [64];
  int ne = 0;

  always @(negedge clk) begin
    if (q_wr && ne < 64) begin
      e_data[ne] = q_data;
      e_be[ne]   = q_be;
      e_addr[ne] = q_addr_ent;
      e_eot[ne]  = q_eot;
      ne++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dval(input logic [31:0] a, input int k);
    return a ^ (32'h1357_9BDF + 32'(k) * 32'h0101_0101);
  endfunction

  function automatic logic [3:0] cbe_of(input int k);
    return 4'(k * 5);
  endfunction

  task automatic run_vec(input vec_t v);
    bit exp_claim, claimed, stopped, stalled;
    bit pend_beat, pend_last, pend_stop;
    int exp_beats, to_bnd, k, wait_cnt, cyc, dev_cyc, trdy_cyc;
    string breq;
    exp_claim = (v.cmd == 4'b0111 || v.cmd == 4'b1111) && v.hit && !v.vga
                && v.free >= 6'd2;
    if (v.cmd == 4'b1111) begin
      to_bnd = 1024 - int'(v.addr[11:2]);
      breq = "R7";
    end else begin
      to_bnd = int'(v.cls) - (int'(v.addr[31:2]) % int'(v.cls));
      breq = "R6";
    end
    exp_beats = int'(v.n);
    if (to_bnd < exp_beats) exp_beats = to_bnd;
    if (int'(v.free) - 1 < exp_beats) begin
      exp_beats = int'(v.free) - 1;
      breq = "R8";
    end
    addr_hit = v.hit; vga_hit = v.vga; q_free = v.free; cls_dw = v.cls;
    ne = 0;
    @(negedge clk);
    frame_n = 1'b0; ad = v.addr; cbe_n = v.cmd;
    @(negedge clk);
    cyc = 1;
    chk(devsel_n == 1'b1, "R2", "no fast decode", devsel_n, 1);
    frame_n = (v.n == 8'd1); irdy_n = 1'b0; ad = dval(v.addr, 0); cbe_n = cbe_of(0);
    k = 0; wait_cnt = 0; claimed = 0; stopped = 0; stalled = 0;
    dev_cyc = 0; trdy_cyc = 0; pend_beat = 0; pend_last = 0; pend_stop = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (!devsel_n && !claimed) begin claimed = 1; dev_cyc = cyc; end
      if (!trdy_n && trdy_cyc == 0) trdy_cyc = cyc;
      if (pend_beat) begin
        k++;
        if (pend_last) begin irdy_n = 1'b1; frame_n = 1'b1; break; end
        if (pend_stop) begin
          stopped = 1;
          chk(stop_n == 1'b0 && trdy_n == 1'b1 && devsel_n == 1'b0, "R9",
              "hold after disconnect", {stop_n, trdy_n, devsel_n}, 3'b010);
          frame_n = 1'b1;
          @(negedge clk);
          chk(stop_n && devsel_n && trdy_n, "R9", "release after FRAME# high",
              {stop_n, trdy_n, devsel_n}, 3'b111);
          irdy_n = 1'b1;
          break;
        end
        ad = dval(v.addr, k); cbe_n = cbe_of(k); frame_n = (k == int'(v.n) - 1);
        if (v.stall && k == 1 && !stalled) begin irdy_n = 1'b1; stalled = 1; end
      end else if (irdy_n) begin
        irdy_n = 1'b0;
      end else if (!claimed) begin
        wait_cnt++;
        if (wait_cnt > 4) begin frame_n = 1'b1; irdy_n = 1'b1; break; end
      end
      pend_beat = !irdy_n && !trdy_n && !devsel_n;
      pend_last = frame_n;
      pend_stop = !stop_n;
    end
    chk(devsel_n && trdy_n && stop_n, "R5", "bus released",
        {devsel_n, trdy_n, stop_n}, 3'b111);
    repeat (2) @(negedge clk);
    chk(claimed == exp_claim, v.free < 6'd2 ? "R3" : "R1", "claim", claimed, exp_claim);
    if (exp_claim && claimed) begin
      chk(dev_cyc == 2, "R2", "DEVSEL# cycle", dev_cyc, 2);
      chk(trdy_cyc == 3, "R2", "TRDY# cycle", trdy_cyc, 3);
      chk(ne == exp_beats + 1, "R4", "queue entries", ne, exp_beats + 1);
      chk(stopped == (exp_beats < int'(v.n)), breq, "disconnect", stopped,
          exp_beats < int'(v.n));
      if (ne == exp_beats + 1) begin
        chk(e_addr[0] && e_data[0] == {v.addr[31:2], 2'b00} && e_be[0] == v.cmd,
            "R10", "address entry", e_data[0], {v.addr[31:2], 2'b00});
        for (int i = 1; i < ne; i++) begin
          chk(!e_addr[i] && e_data[i] == dval(v.addr, i - 1)
              && e_be[i] == ~cbe_of(i - 1), "R10", "data entry",
              e_data[i], dval(v.addr, i - 1));
          chk(e_eot[i] == (i == ne - 1), "R5", "end marker", e_eot[i], i == ne - 1);
        end
      end
    end else begin
      chk(ne == 0, "R1", "no queue writes", ne, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !q_wr, "R5", "reset state",
        {devsel_n, trdy_n, stop_n, q_wr}, 4'b1110);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i]);
      repeat (2) @(negedge clk);
    end
    // R7: MWI ending exactly on a page edge with a tiny cache line set
    run_vec('{4'b1111, 32'h0000_0FF0, 8'd4, 6'd30, 8'd2, 1'b1, 1'b0, 1'b0});
    // R8: exactly two slots gives one beat
    run_vec('{4'b0111, 32'h0000_0000, 8'd3, 6'd2, 8'd64, 1'b1, 1'b0, 1'b0});
    // R6: one-DWORD line disconnects every beat
    run_vec('{4'b0111, 32'h0000_0500, 8'd3, 6'd20, 8'd1, 1'b1, 1'b0, 1'b0});
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule